// File: doc/BRIEF.md
# PS/2 Event Forwarding Engine with Upstream Credit

This block sits between a host mailbox and two byte-wide PS/2 port endpoints. Port 0 is a keyboard and port 1 is a pointing device. The host sends 16-bit commands through a command FIFO. The engine reads the FIFO head, decodes the port number, and hands the data byte to the transmitter of the selected port. Bit-level PS/2 timing belongs to the port endpoints, not to this block.

In the other direction, bytes received on either port become 16-bit events and wait in an upstream queue. The host may receive only one event at a time. After it has consumed an event, it returns a ready token (command value 0xFF00). That token allows the engine to place exactly one event in the response register and pulse the host interrupt. If the token arrives while the queue is empty, the engine keeps a credit flag instead. The next event then goes straight to the host without waiting in the queue.

Command handling stops while either port is busy, so a new transmit request never overlaps a byte transfer that is still in progress.

Top module: `ps2_evt_fwd`

## Requirements
- R1: A command is decoded as port = bits 15:8 and data = bits 7:0. Port 0x00 raises `kbd_tx_req` and port 0x01 raises `aux_tx_req`. The request is a one-cycle pulse, appears on the cycle after the pop, and carries the data byte on `tx_data`.
- R2: The command value 0xFF00 is a ready token. It is popped but never raises a transmit request.
- R3: A command whose port field is neither 0x00 nor 0x01, and which is not 0xFF00, is popped and discarded with no output activity.
- R4: `cmd_pop` is asserted, combinationally and for at most one command per cycle, only when all four of these hold:
  - `cmd_valid` is high;
  - `kbd_busy` is low;
  - `aux_busy` is low;
  - neither transmit request is high.
- R5: When a ready token is accepted and the upstream queue holds events, the oldest event is removed. On the next cycle `resp_we` and `host_irq` pulse together, with that event on `resp_data`.
- R6: When a ready token is accepted and the queue is empty, a credit is stored. The next event to arrive is sent directly, with the response on the following cycle, and the credit is then cleared.
- R7: An event is formatted with the data byte in bits 7:0 and the port number in bits 15:8 (0x00 keyboard, 0x01 pointing device).
- R8: After reset all outputs are low and a credit is already held, so the first event is forwarded without a token.
- R9: The queue holds QDEPTH (default 8) events in arrival order. When both ports deliver a byte in the same cycle, the keyboard byte counts as the earlier one.
- R10: When the queue is full, the newest arriving event is dropped and the sticky `ovf_err` is set. It is cleared only by reset.
- R11: Without a credit, an arriving event produces no response and waits in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command FIFO holds an entry |
| cmd_data | input | 16 | Command FIFO head |
| cmd_pop | output | 1 | Remove the head entry this cycle |
| kbd_rx_stb | input | 1 | Keyboard received a byte |
| kbd_rx_data | input | 8 | Keyboard received byte |
| aux_rx_stb | input | 1 | Pointing device received a byte |
| aux_rx_data | input | 8 | Pointing device received byte |
| kbd_busy | input | 1 | Keyboard endpoint is mid-byte |
| aux_busy | input | 1 | Pointing device endpoint is mid-byte |
| kbd_tx_req | output | 1 | Transmit pulse to keyboard |
| aux_tx_req | output | 1 | Transmit pulse to pointing device |
| tx_data | output | 8 | Byte to transmit |
| resp_we | output | 1 | Response register write |
| resp_data | output | 16 | Event written to response register |
| host_irq | output | 1 | Host interrupt trigger pulse |
| ovf_err | output | 1 | Sticky upstream overflow flag |

## Verification
The embedded properties assume two things about the inputs: the receive strobes are single-cycle pulses, and `cmd_data` is stable for as long as `cmd_valid` is high and no pop occurs. The bench supplies the commands from its own queue and holds the head value until the engine pops it. It produces busy levels, strobes and commands from a seeded random source, and returns a ready token each time it sees a response. This keeps the credit protocol legal while still covering several cases: tokens that find an empty queue, tokens that find a non-empty queue, arrivals on both ports in the same cycle, and runs without any token that drive the queue into overflow.

// File: rtl/ps2fwd_pkg.sv
package ps2fwd_pkg;
  localparam int CMD_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [CMD_W-1:0] READY_TOKEN = 16'hFF00;

  typedef enum logic [1:0] {
    CMD_KBD   = 2'd0,
    CMD_AUX   = 2'd1,
    CMD_TOKEN = 2'd2,
    CMD_DROP  = 2'd3
  } cmd_kind_e;

  // Upstream event word: port number above, received byte below.
  function automatic logic [CMD_W-1:0] pack_evt(input logic port_sel,
                                                input logic [BYTE_W-1:0] d);
    return {7'd0, port_sel, d};
  endfunction

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] c);
    if (c == READY_TOKEN) return CMD_TOKEN;
    case (c[15:8])
      8'h00:   return CMD_KBD;
      8'h01:   return CMD_AUX;
      default: return CMD_DROP;
    endcase
  endfunction
endpackage

// File: rtl/ps2fwd_cmd_gate.sv
module ps2fwd_cmd_gate
  import ps2fwd_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             kbd_busy,
  input  logic             aux_busy,
  input  logic             tx_pending,
  output logic             cmd_pop,
  output cmd_kind_e        cmd_kind
);
  logic ports_idle;
  assign ports_idle = !kbd_busy && !aux_busy && !tx_pending;
  assign cmd_pop    = cmd_valid && ports_idle;
  assign cmd_kind   = classify(cmd_data);
endmodule

// File: rtl/ps2fwd_evt_queue.sv
module ps2fwd_evt_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] data_a,
  input  logic         push_b,
  input  logic [W-1:0] data_b,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p, input int inc);
    int s;
    s = int'(p) + inc;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, idx_b;
  logic [CNT_W-1:0] count_q;
  int               free_slots;
  logic             acc_a, acc_b;

  assign free_slots = DEPTH - int'(count_q) + (pop ? 1 : 0);
  assign acc_a      = push_a && (free_slots >= 1);
  assign acc_b      = push_b && (free_slots >= (acc_a ? 2 : 1));
  assign drop       = (push_a && !acc_a) || (push_b && !acc_b);
  assign idx_b      = acc_a ? wrap_inc(wr_ptr, 1) : wr_ptr;
  assign head       = mem[rd_ptr];
  assign empty      = (count_q == '0);

  always_ff @(posedge clk) begin
    if (acc_a) mem[wr_ptr] <= data_a;
    if (acc_b) mem[idx_b]  <= data_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      wr_ptr  <= wrap_inc(wr_ptr, int'(acc_a) + int'(acc_b));
      if (pop) rd_ptr <= wrap_inc(rd_ptr, 1);
      count_q <= CNT_W'(int'(count_q) + int'(acc_a) + int'(acc_b) - int'(pop));
    end
  end

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);
  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);
endmodule

// File: rtl/ps2fwd_credit.sv
module ps2fwd_credit
  import ps2fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              token_acc,
  input  logic              q_empty,
  input  logic [CMD_W-1:0]  q_head,
  input  logic              kbd_stb,
  input  logic [BYTE_W-1:0] kbd_data,
  input  logic              aux_stb,
  input  logic [BYTE_W-1:0] aux_data,
  output logic              q_pop,
  output logic              push_a,
  output logic [CMD_W-1:0]  data_a,
  output logic              push_b,
  output logic [CMD_W-1:0]  data_b,
  output logic              resp_we,
  output logic [CMD_W-1:0]  resp_data,
  output logic              host_irq
);
  logic             ok_q, credit, direct_kbd, direct_aux, send;
  logic [CMD_W-1:0] send_data;

  assign credit     = ok_q || (token_acc && q_empty);
  assign q_pop      = token_acc && !q_empty;
  assign direct_kbd = credit && kbd_stb;
  assign direct_aux = credit && aux_stb && !kbd_stb;
  assign data_a     = pack_evt(1'b0, kbd_data);
  assign data_b     = pack_evt(1'b1, aux_data);
  assign push_a     = kbd_stb && !direct_kbd;
  assign push_b     = aux_stb && !direct_aux;
  assign send       = q_pop || direct_kbd || direct_aux;

  always_comb begin
    if (q_pop)           send_data = q_head;
    else if (direct_kbd) send_data = data_a;
    else                 send_data = data_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q      <= 1'b1;
      resp_we   <= 1'b0;
      host_irq  <= 1'b0;
      resp_data <= '0;
    end else begin
      ok_q     <= (direct_kbd || direct_aux) ? 1'b0 : credit;
      resp_we  <= send;
      host_irq <= send;
      if (send) resp_data <= send_data;
    end
  end

  // R6
  credit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> q_empty);
endmodule

// File: rtl/ps2_evt_fwd.sv
module ps2_evt_fwd
  import ps2fwd_pkg::*;
#(
  parameter int QDEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_data,
  output logic        cmd_pop,
  input  logic        kbd_rx_stb,
  input  logic [7:0]  kbd_rx_data,
  input  logic        aux_rx_stb,
  input  logic [7:0]  aux_rx_data,
  input  logic        kbd_busy,
  input  logic        aux_busy,
  output logic        kbd_tx_req,
  output logic        aux_tx_req,
  output logic [7:0]  tx_data,
  output logic        resp_we,
  output logic [15:0] resp_data,
  output logic        host_irq,
  output logic        ovf_err
);
  cmd_kind_e        cmd_kind;
  logic             token_acc, q_pop, q_empty, q_drop;
  logic             push_a, push_b;
  logic [CMD_W-1:0] data_a, data_b, q_head;

  ps2fwd_cmd_gate gate_i (
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .kbd_busy  (kbd_busy),
    .aux_busy  (aux_busy),
    .tx_pending(kbd_tx_req || aux_tx_req),
    .cmd_pop   (cmd_pop),
    .cmd_kind  (cmd_kind)
  );

  assign token_acc = cmd_pop && (cmd_kind == CMD_TOKEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_tx_req <= 1'b0;
      aux_tx_req <= 1'b0;
      tx_data    <= '0;
      ovf_err    <= 1'b0;
    end else begin
      kbd_tx_req <= cmd_pop && (cmd_kind == CMD_KBD);
      aux_tx_req <= cmd_pop && (cmd_kind == CMD_AUX);
      if (cmd_pop && (cmd_kind == CMD_KBD || cmd_kind == CMD_AUX))
        tx_data <= cmd_data[7:0];
      if (q_drop) ovf_err <= 1'b1;
    end
  end

  ps2fwd_credit credit_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .token_acc(token_acc),
    .q_empty  (q_empty),
    .q_head   (q_head),
    .kbd_stb  (kbd_rx_stb),
    .kbd_data (kbd_rx_data),
    .aux_stb  (aux_rx_stb),
    .aux_data (aux_rx_data),
    .q_pop    (q_pop),
    .push_a   (push_a),
    .data_a   (data_a),
    .push_b   (push_b),
    .data_b   (data_b),
    .resp_we  (resp_we),
    .resp_data(resp_data),
    .host_irq (host_irq)
  );

  ps2fwd_evt_queue #(.DEPTH(QDEPTH), .W(CMD_W)) queue_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push_a(push_a),
    .data_a(data_a),
    .push_b(push_b),
    .data_b(data_b),
    .pop   (q_pop),
    .head  (q_head),
    .empty (q_empty),
    .drop  (q_drop)
  );

  // R1
  tx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_tx_req, aux_tx_req}));
  // R2
  token_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_acc |=> !kbd_tx_req && !aux_tx_req);
  // R4
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_tx_req || aux_tx_req) |-> !cmd_pop);
  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

// File: tb/ps2_evt_fwd_tb_top.sv
`timescale 1ns/1ps
module ps2_evt_fwd_tb_top;
  localparam int QD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_pop;
  logic        kbd_rx_stb = 1'b0, aux_rx_stb = 1'b0;
  logic [7:0]  kbd_rx_data = '0, aux_rx_data = '0;
  logic        kbd_busy = 1'b0, aux_busy = 1'b0;
  logic        kbd_tx_req, aux_tx_req, resp_we, host_irq, ovf_err;
  logic [7:0]  tx_data;
  logic [15:0] resp_data;

  always #5 clk = ~clk;

  ps2_evt_fwd #(.QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .kbd_rx_stb(kbd_rx_stb), .kbd_rx_data(kbd_rx_data),
    .aux_rx_stb(aux_rx_stb), .aux_rx_data(aux_rx_data), .kbd_busy(kbd_busy),
    .aux_busy(aux_busy), .kbd_tx_req(kbd_tx_req), .aux_tx_req(aux_tx_req),
    .tx_data(tx_data), .resp_we(resp_we), .resp_data(resp_data),
    .host_irq(host_irq), .ovf_err(ovf_err)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // Behavioural reference state
  logic [15:0] cq[$];
  logic [15:0] uq[$];
  bit          ok_m = 1;
  bit          exp_ktx = 0, exp_atx = 0, exp_we = 0, exp_ovf = 0;
  logic [7:0]  exp_txd = '0;
  logic [15:0] exp_rd = '0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input bit kv, input logic [7:0] kd, input bit av,
                      input logic [7:0] ad, input bit kb, input bit ab);
    bit idle, acc, tok, credit, hs, dk, da;
    logic [15:0] c;
    @(negedge clk);
    chk("R1 kbd_tx_req", kbd_tx_req, exp_ktx);
    chk("R1 aux_tx_req", aux_tx_req, exp_atx);
    if (exp_ktx || exp_atx) chk("R1 tx_data", tx_data, exp_txd);
    chk("R5 R6 R11 resp_we", resp_we, exp_we);
    chk("R5 host_irq", host_irq, exp_we);
    if (exp_we) chk("R7 R9 resp_data", resp_data, exp_rd);
    chk("R10 ovf_err", ovf_err, exp_ovf);
    kbd_rx_stb = kv; kbd_rx_data = kd; aux_rx_stb = av; aux_rx_data = ad;
    kbd_busy = kb; aux_busy = ab;
    cmd_valid = (cq.size() != 0);
    cmd_data = (cq.size() != 0) ? cq[0] : 16'h0;
    #1;
    idle = !kb && !ab && !exp_ktx && !exp_atx;
    acc = (cq.size() != 0) && idle;
    c = cmd_data;
    chk("R4 cmd_pop", cmd_pop, acc);
    tok = acc && (c == 16'hFF00);
    exp_ktx = acc && !tok && (c[15:8] == 8'h00);
    exp_atx = acc && !tok && (c[15:8] == 8'h01);
    if (exp_ktx || exp_atx) exp_txd = c[7:0];
    credit = ok_m || (tok && uq.size() == 0);
    hs = tok && (uq.size() != 0);
    exp_we = 0;
    if (hs) begin exp_we = 1; exp_rd = uq.pop_front(); end
    dk = credit && kv;
    da = credit && av && !kv;
    if (dk) begin exp_we = 1; exp_rd = {8'h00, kd}; end
    if (da) begin exp_we = 1; exp_rd = {8'h01, ad}; end
    if (kv && !dk) begin
      if (uq.size() < QD) uq.push_back({8'h00, kd}); else exp_ovf = 1;
    end
    if (av && !da) begin
      if (uq.size() < QD) uq.push_back({8'h01, ad}); else exp_ovf = 1;
    end
    ok_m = (dk || da) ? 1'b0 : credit;
    if (acc) void'(cq.pop_front());
  endtask

  task automatic idle_steps(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h0, 0, 8'h0, 0, 0);
  endtask

  // sample registered outputs just after the edge that follows the last step
  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk);
    chk("R8 kbd_tx_req reset", kbd_tx_req, 0);
    chk("R8 aux_tx_req reset", aux_tx_req, 0);
    chk("R8 resp_we reset", resp_we, 0);
    chk("R8 host_irq reset", host_irq, 0);
    chk("R8 ovf_err reset", ovf_err, 0);
    @(negedge clk); rst_n = 1'b1;
    idle_steps(2);

    // R1 R3 R4: downstream forwarding, invalid port, busy hold
    cq.push_back(16'h0011); cq.push_back(16'h0122);
    cq.push_back(16'h0533); cq.push_back(16'h0044);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R1 keyboard request", {kbd_tx_req, aux_tx_req, tx_data}, 16'h0211);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R1 aux request", {kbd_tx_req, aux_tx_req, tx_data}, 16'h0122);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R3 invalid port discarded", {kbd_tx_req, aux_tx_req}, 0);
    idle_steps(4);
    chk("R3 command FIFO drained", cq.size(), 0);

    // R8 R6: initial credit lets the first event through
    step(1, 8'h1C, 0, 0, 0, 0);
    after_edge();
    chk("R8 first event direct", {resp_we, host_irq}, 2'b11);
    chk("R7 first event word", resp_data, 16'h001C);
    // R11 R9: no credit, same-cycle pair queued keyboard first
    step(1, 8'h2A, 1, 8'h08, 0, 0);
    after_edge();
    chk("R11 held without credit", resp_we, 0);
    idle_steps(2);
    // R2 R5: tokens drain in order
    cq.push_back(16'hFF00);
    step(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R2 token not forwarded", {kbd_tx_req, aux_tx_req}, 0);
    chk("R5 token sends head", resp_data, 16'h002A);
    cq.push_back(16'hFF00);
    step(0, 0, 0, 0, 0, 0);
    after_edge();
    chk("R9 second in order", resp_data, 16'h0108);
    // R6: token on empty queue stores credit
    cq.push_back(16'hFF00);
    idle_steps(3);
    after_edge();
    chk("R6 no response without event", resp_we, 0);
    step(0, 0, 1, 8'h10, 0, 0);
    after_edge();
    chk("R6 credited event sent", resp_data, 16'h0110);
    step(1, 8'h55, 0, 0, 0, 0);
    after_edge();
    chk("R6 credit consumed", resp_we, 0);

    // R10: overflow, then drain
    for (int i = 0; i < 9; i++) step(1, 8'(8'h60 + i), 0, 0, 0, 0);
    after_edge();
    chk("R10 overflow sticky set", ovf_err, 1);
    for (int i = 0; i < QD; i++) begin
      cq.push_back(16'hFF00);
      idle_steps(2);
    end
    idle_steps(3);
    chk("R10 queue drained", uq.size(), 0);

    // Mixed random traffic with a host that returns a token per response
    for (int i = 0; i < 3000; i++) begin
      bit kv, av, kb, ab;
      kv = ($urandom_range(0, 3) == 0);
      av = ($urandom_range(0, 4) == 0);
      kb = ($urandom_range(0, 5) == 0);
      ab = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 7) == 0)
        cq.push_back({8'($urandom_range(0, 2)), 8'($urandom_range(0, 255))});
      if ($urandom_range(0, 40) == 0) cq.push_back(16'hFF00);
      step(kv, 8'($urandom_range(0, 255)), av, 8'($urandom_range(0, 255)), kb, ab);
      if (exp_we) cq.push_back(16'hFF00);
    end
    idle_steps(40);
    done = 1;
    finish_run();
  end
endmodule